// File: doc/BRIEF.md
# Loadable Stall Down-Counter

This block produces a stall signal that lasts a programmable number of cycles, for use beside a pipeline stage that must wait (for example, a multi-cycle array access). An enable pulse together with a length value starts a countdown. The stall output is meant to feed the "target busy" or "dependency pending" input of a stage's flow control. The length may be a constant or may be taken from a field of the token's payload, so each token can stall for a different time.

The block also masks a stage's token with the inverse of the stall. The token therefore becomes visible downstream only once the countdown has run out. A new length is taken only when the countdown is idle (count 0 or 1). An enable that arrives while the stall is raised is dropped. All pins are plain control levels with no handshake: the stall output is the back-pressure signal, and the token pair has no valid/ready of its own.

Top module: `stall_countdown`

## Requirements
- R1: After reset the internal count is 0: `stall` is low and `tok_out` follows `tok_in`.
- R2: `stall` is high in exactly the cycles in which the count is greater than 1.
- R3: On a clock edge with the count greater than 1, the count drops by one.
- R4: On a clock edge with the count at 0 or 1 and `load_en` high, the count takes `load_len`. A load of N ≥ 2 gives exactly N−1 stall cycles, starting the cycle after the load edge.
- R5: On a clock edge with the count at 0 or 1 and `load_en` low, the count becomes 0.
- R6: While `stall` is high, `load_en` and `load_len` have no effect. The stall that is running ends at the same cycle as it would with `load_en` low.
- R7: A load of 0 or 1 gives no stall cycle.
- R8: `tok_out` equals `tok_in` AND NOT `stall`, in the same cycle.
- R9: If `load_en` is held high, a reload is taken in the cycle in which the count has reached 1. That gives exactly one cycle without stall between two countdowns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Request to start a countdown |
| load_len | input | CNT_W | Countdown length to load |
| tok_in | input | 1 | Token of the guarded stage |
| stall | output | 1 | High while the countdown runs |
| tok_out | output | 1 | Token masked by the stall |

## Verification
The bench sweeps every length that a 4-bit counter can hold, once with the enable low during the countdown and once with it held high. The first pass measures the plain stall length for each value, including the 0 and 1 no-stall cases. The second pass shows that requests made during a stall are dropped: the length stays the same and the garbage length input is never loaded. A back-to-back run with the enable held high throughout checks the single idle cycle between reloads. In every cycle the token input is toggled, which separates a correct mask from one that passes or blocks the token regardless of the stall.

// File: rtl/stall_cnt_pkg.sv
package stall_cnt_pkg;
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DEC   = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/stall_cnt_next.sv
module stall_cnt_next
  import stall_cnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_len,
  output cnt_act_e         act,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    busy = (cnt > ONE);
    if (busy)         act = ACT_DEC;
    else if (load_en) act = ACT_LOAD;
    else              act = ACT_CLEAR;
  end

  always_comb begin
    unique case (act)
      ACT_DEC:  cnt_nxt = cnt - ONE;
      ACT_LOAD: cnt_nxt = load_len;
      default:  cnt_nxt = '0;
    endcase
  end
endmodule

// File: rtl/stall_cnt_reg.sv
module stall_cnt_reg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] d,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/stall_tok_gate.sv
module stall_tok_gate (
  input  logic tok_in,
  input  logic hold,
  output logic tok_out
);
  always_comb tok_out = tok_in & ~hold;
endmodule

// File: rtl/stall_countdown.sv
module stall_countdown
  import stall_cnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_len,
  input  logic             tok_in,
  output logic             stall,
  output logic             tok_out
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  cnt_act_e         act;

  stall_cnt_next #(.CNT_W(CNT_W)) u_next (
    .cnt      (cnt_q),
    .load_en  (load_en),
    .load_len (load_len),
    .act      (act),
    .cnt_nxt  (cnt_d),
    .busy     (stall)
  );

  stall_cnt_reg #(.CNT_W(CNT_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cnt_d),
    .q     (cnt_q)
  );

  stall_tok_gate u_gate (
    .tok_in  (tok_in),
    .hold    (stall),
    .tok_out (tok_out)
  );
endmodule

// File: rtl/stall_countdown_chk.sv
module stall_countdown_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [CNT_W-1:0] load_len,
  input logic             tok_in,
  input logic             stall,
  input logic             tok_out,
  input logic [CNT_W-1:0] cnt
);
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> cnt == $past(cnt) - CNT_W'(1));

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load_en) |=> cnt == $past(load_len));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load_en) |=> cnt == '0);

  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && load_en) |=> cnt != $past(load_len) || $past(load_len) == $past(cnt) - CNT_W'(1));

  a_r7_short_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load_en && load_len <= CNT_W'(1)) |=> !stall);

  a_r8_mask_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !tok_out);

  a_r8_pass_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> tok_out == tok_in);
endmodule

bind stall_countdown stall_countdown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_en  (load_en),
  .load_len (load_len),
  .tok_in   (tok_in),
  .stall    (stall),
  .tok_out  (tok_out),
  .cnt      (cnt_q)
);

// File: tb/tb_stall_countdown.sv
`timescale 1ns/1ps
module tb_stall_countdown;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_len = '0;
  logic         tok_in = 1'b0;
  logic         stall;
  logic         tok_out;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stall_countdown #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_len(load_len),
    .tok_in(tok_in), .stall(stall), .tok_out(tok_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare with the model, then advance the model at posedge.
  task automatic step(input bit en, input int len, input bit tk, output bit st);
    @(negedge clk);
    load_en = en; load_len = W'(len); tok_in = tk;
    #0.5;
    chk("R2 stall level", int'(stall), int'(model > 1));
    chk("R8 token mask", int'(tok_out), int'(tk && !(model > 1)));
    st = stall;
    @(posedge clk);
    if (model > 1)  model = model - 1;
    else if (en)    model = len;
    else            model = 0;
  endtask

  task automatic run_len(input int n, input bit en_during);
    bit st;
    int seen = 0;
    step(1'b1, n, 1'b1, st);
    for (int j = 0; j < n + 1; j++) begin
      bit e = en_during && (j < n - 1);
      step(e, (~n) & ((1 << W) - 1), j[0], st);
      if (st) seen++;
    end
    if (n <= 1) chk("R7 no stall for short load", seen, 0);
    else if (en_during) chk("R6 ignored enable keeps length", seen, n - 1);
    else chk("R4 stall length", seen, n - 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit st;
    load_en = 1'b1; load_len = W'(9); tok_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    load_en = 1'b0;
    #0.5;
    chk("R1 reset stall", int'(stall), 0);
    chk("R1 reset token", int'(tok_out), 1);
    model = 0;
    @(posedge clk);

    for (int n = 0; n < (1 << W); n++) run_len(n, 1'b0);
    for (int n = 0; n < (1 << W); n++) run_len(n, 1'b1);

    // R3/R5: after a load of 5, the stall lasts 4 cycles and then clears with the enable low.
    step(1'b1, 5, 1'b1, st);
    for (int j = 0; j < 4; j++) begin
      step(1'b0, 0, 1'b1, st);
      chk("R3 countdown stall", int'(st), 1);
    end
    step(1'b0, 0, 1'b1, st);
    chk("R5 idle after count 1", int'(st), 0);
    step(1'b0, 0, 1'b1, st);
    chk("R5 count cleared", int'(st), 0);

    // R9: enable held high with length 3: stall, stall, gap, stall, stall, gap.
    step(1'b1, 3, 1'b0, st);
    for (int j = 0; j < 6; j++) begin
      step(1'b1, 3, 1'b1, st);
      chk("R9 back-to-back pattern", int'(st), int'((j % 3) != 2));
    end
    step(1'b0, 0, 1'b0, st);
    step(1'b0, 0, 1'b0, st);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule